// File: doc/BRIEF.md
# Native DSP Float to IEEE-754 Single Converter

This block turns a floating-point word in a DSP-native encoding into an IEEE-754 single-precision word. The native encoding keeps its exponent as an 8-bit two's-complement number in the top byte. It also places a sign flag just below that byte. Its mantissa is a two's-complement quantity with an implied leading bit. A negative native value therefore has to be negated into sign-magnitude form, and the carry that this negation can produce must be folded into the exponent.

Two input widths are accepted. A select bit chooses between the full 32-bit native word and a 16-bit short float held in the low half of the data input. The short form has a 4-bit exponent, a sign bit and an 11-bit fraction. It is first widened into the 32-bit layout and then takes the same path as a full word. One register stage sits at the output. Each accepted word yields the packed IEEE result one clock later, together with a flag for a zero input and a flag for a result that saturated to infinity.

Top module: `nf2i_convert`

## Requirements
- R1: For a full 32-bit input (`in_short`=0) with a non-reserved exponent and the sign bit (bit 23) clear, the result takes bit 31 from input bit 23. Its bits 30:23 are the input exponent (bits 31:24) plus 127 modulo 256. Its bits 22:0 are the input fraction (bits 22:0).
- R2: A full-word exponent field equal to 8'h80 means zero. The result is then 32'h0000_0000 with `out_zero`=1, whatever the sign and fraction bits hold.
- R3: When the native sign bit is set, the output fraction is the two's complement of the input fraction, reduced to 23 bits. The carry out of that negation, which arises only for a fraction of zero, adds one to the biased exponent modulo 256. Output bit 31 is 1.
- R4: If the final biased exponent equals 8'hFF, the result saturates to infinity with the native sign: 32'h7F80_0000 or 32'hFF80_0000. `out_ovf` is set.
- R5: For a short input (`in_short`=1), the value is zero when bits 15:12 equal 4'b1000. The result is then 32'h0 with `out_zero`=1.
- R6: Any other short input is widened to a native word as follows. The exponent is bits 15:12, sign-extended to 8 bits. The sign is bit 11. The fraction is bits 10:0 followed by twelve zero bits. The widened word is then converted by R1 to R4.
- R7: With `in_short`=1, bits 31:16 of `in_word` have no effect on any output.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock. A synchronous active-high `rst` clears `out_valid`, `out_ieee` and both flags.
- R9: In a cycle with `in_valid`=0, `out_ieee`, `out_zero` and `out_ovf` keep their previous values.
- R10: `out_zero` and `out_ovf` are never set together. A result with neither flag is the packed word {sign, exponent, fraction}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present this cycle |
| in_short | input | 1 | 1: low 16 bits hold a short float; 0: full 32-bit native word |
| in_word | input | 32 | Native float data |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_ieee | output | 32 | IEEE-754 single-precision result |
| out_zero | output | 1 | Input was a reserved-zero encoding |
| out_ovf | output | 1 | Result saturated to signed infinity |

## Verification
The checker enforces several properties on every clock. It checks the one-cycle valid latency and the holding of results while idle. It checks that each flag forces its output pattern and that the two flags never occur together. It checks that the reserved-zero encodings of both widths raise the zero flag, and that the sign of a full-word input reaches bit 31. The exact fraction negation, the carry into the exponent, the widening of short floats and the rule that upper bits are ignored in short mode can only be shown by the bench. The bench sweeps every 16-bit short float with junk in the upper half of the data input. It also covers all 256 exponents with both signs and boundary fractions, then a random set of full words. Each result is compared with an independent sign-magnitude reconstruction of the native value.

// File: rtl/nf2i_pkg.sv
package nf2i_pkg;
  // Native and IEEE word geometry
  localparam int NAT_W     = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int SH_W      = 16;
  localparam int SH_EXP_W  = 4;
  localparam int SH_FRAC_W = 11;
  localparam int EXT_W     = EXP_W - SH_EXP_W;
  localparam int PAD_W     = NAT_W - SH_W - EXT_W;

  localparam logic [EXP_W-1:0]    ZERO_EXP    = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic [EXP_W-1:0]    EXP_BIAS    = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0]    EXP_MAX     = {EXP_W{1'b1}};
  localparam logic [SH_EXP_W-1:0] SH_ZERO_EXP = {1'b1, {(SH_EXP_W-1){1'b0}}};

  typedef struct packed {
    logic [EXP_W-1:0]  exp;
    logic              sign;
    logic [FRAC_W-1:0] frac;
  } nat_word_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } ieee_word_t;

  // Re-bias a two's-complement exponent (wraps modulo 2^EXP_W)
  function automatic logic [EXP_W-1:0] rebias(input logic [EXP_W-1:0] e);
    return e + EXP_BIAS;
  endfunction

  // Negate a fraction; MSB of result is the carry out of the top fraction bit
  function automatic logic [FRAC_W:0] negate_frac(input logic [FRAC_W-1:0] f);
    return {1'b0, ~f} + {{FRAC_W{1'b0}}, 1'b1};
  endfunction

  // Place a short float in the full native layout (arithmetic alignment)
  function automatic logic [NAT_W-1:0] widen_short(input logic [SH_W-1:0] h);
    return {{EXT_W{h[SH_W-1]}}, h, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/nf2i_widen.sv
module nf2i_widen
  import nf2i_pkg::*;
(
  input  logic             in_short,
  input  logic [NAT_W-1:0] in_word,
  output logic [NAT_W-1:0] nat_word,
  output logic             short_zero
);
  logic [SH_W-1:0] half;

  assign half       = in_word[SH_W-1:0];
  assign short_zero = in_short && (half[SH_W-1 -: SH_EXP_W] == SH_ZERO_EXP);

  always_comb begin
    if (!in_short)
      nat_word = in_word;
    else if (short_zero)
      nat_word = {ZERO_EXP, {(NAT_W-EXP_W){1'b0}}};
    else
      nat_word = widen_short(half);
  end
endmodule

// File: rtl/nf2i_core.sv
module nf2i_core
  import nf2i_pkg::*;
(
  input  logic [NAT_W-1:0] nat_word,
  output logic [NAT_W-1:0] ieee_word,
  output logic             is_zero,
  output logic             is_ovf
);
  nat_word_t         n;
  ieee_word_t        r;
  logic              neg;
  logic [FRAC_W:0]   neg_res;
  logic              frac_carry;
  logic [FRAC_W-1:0] frac_out;
  logic [EXP_W-1:0]  exp_biased;
  logic [EXP_W-1:0]  exp_final;

  assign n          = nat_word_t'(nat_word);
  assign neg        = n.sign;
  assign is_zero    = (n.exp == ZERO_EXP);
  assign neg_res    = negate_frac(n.frac);
  assign frac_carry = neg & neg_res[FRAC_W];
  assign frac_out   = neg ? neg_res[FRAC_W-1:0] : n.frac;
  assign exp_biased = rebias(n.exp);
  assign exp_final  = exp_biased + {{(EXP_W-1){1'b0}}, frac_carry};
  assign is_ovf     = !is_zero && (exp_final == EXP_MAX);

  always_comb begin
    if (is_zero) begin
      r = '0;
    end else if (is_ovf) begin
      r.sign = neg;
      r.exp  = EXP_MAX;
      r.frac = '0;
    end else begin
      r.sign = neg;
      r.exp  = exp_final;
      r.frac = frac_out;
    end
  end

  assign ieee_word = NAT_W'(r);
endmodule

// File: rtl/nf2i_outreg.sv
module nf2i_outreg
  import nf2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NAT_W-1:0] d_word,
  input  logic             d_zero,
  input  logic             d_ovf,
  output logic             q_valid,
  output logic [NAT_W-1:0] q_word,
  output logic             q_zero,
  output logic             q_ovf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_word  <= '0;
      q_zero  <= 1'b0;
      q_ovf   <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_word <= d_word;
        q_zero <= d_zero;
        q_ovf  <= d_ovf;
      end
    end
  end
endmodule

// File: rtl/nf2i_convert.sv
module nf2i_convert
  import nf2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_short,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [31:0] out_ieee,
  output logic        out_zero,
  output logic        out_ovf
);
  // Internal events brought out as named wires
  logic [NAT_W-1:0] nat_word;
  logic             short_zero;
  logic [NAT_W-1:0] core_ieee;
  logic             core_zero;
  logic             core_ovf;

  nf2i_widen u_widen (
    .in_short   (in_short),
    .in_word    (in_word),
    .nat_word   (nat_word),
    .short_zero (short_zero)
  );

  nf2i_core u_core (
    .nat_word  (nat_word),
    .ieee_word (core_ieee),
    .is_zero   (core_zero),
    .is_ovf    (core_ovf)
  );

  nf2i_outreg u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d_word  (core_ieee),
    .d_zero  (core_zero | short_zero),
    .d_ovf   (core_ovf),
    .q_valid (out_valid),
    .q_word  (out_ieee),
    .q_zero  (out_zero),
    .q_ovf   (out_ovf)
  );
endmodule

// File: rtl/nf2i_checker.sv
module nf2i_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_short,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [31:0] out_ieee,
  input logic        out_zero,
  input logic        out_ovf
);
  // R8: valid latency of one clock
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: results hold while idle
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_ieee) && $stable(out_zero) && $stable(out_ovf)));

  // R2: zero flag forces an all-zero word
  a_r2_zero_pattern: assert property (@(posedge clk) disable iff (rst)
    out_zero |-> (out_ieee == 32'h0));

  // R2: reserved full-word exponent raises the zero flag
  a_r2_zero_detect: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_short && in_word[31:24] == 8'h80) |=> out_zero);

  // R5: reserved short exponent raises the zero flag
  a_r5_short_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_short && in_word[15:12] == 4'b1000) |=> out_zero);

  // R4: overflow flag forces a signed infinity
  a_r4_inf_pattern: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_ieee[30:0] == 31'h7F80_0000));

  // R10: flags are exclusive
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_zero && out_ovf));

  // R1: sign of a full word reaches bit 31
  a_r1_sign_copy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_short && in_word[31:24] != 8'h80) |=> (out_ieee[31] == $past(in_word[23])));
endmodule

bind nf2i_convert nf2i_checker u_chk (.*);

// File: tb/nf2i_convert_bench.sv
module nf2i_convert_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_short = 1'b0;
  logic [31:0] in_word = 32'h0;
  logic        out_valid;
  logic [31:0] out_ieee;
  logic        out_zero;
  logic        out_ovf;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  nf2i_convert u_nf2i_convert (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_short  (in_short),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_ieee  (out_ieee),
    .out_zero  (out_zero),
    .out_ovf   (out_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: rebuild the native value as sign-magnitude, then pack.
  // Returns {zero, ovf, ieee}.
  function automatic logic [33:0] model(input logic sh, input logic [31:0] w);
    int e; int f; int mag; int adj; int b; logic s;
    if (sh) begin
      if (w[15:12] == 4'b1000) return {2'b10, 32'h0};
      e = int'($signed(w[15:12]));
      s = w[11];
      f = int'(w[10:0]) * 4096;
    end else begin
      if (w[31:24] == 8'h80) return {2'b10, 32'h0};
      e = int'($signed(w[31:24]));
      s = w[23];
      f = int'(w[22:0]);
    end
    adj = 0;
    if (s) begin
      // native mantissa is -2 + f/2^23; magnitude in units of 2^-23
      mag = 16777216 - f;
      if (mag == 16777216) begin
        adj = 1;
        f = 0;
      end else begin
        f = mag - 8388608;
      end
    end
    b = e + 127 + adj;
    if (b >= 255) return {2'b01, s, 8'hFF, 23'h0};
    return {2'b00, s, b[7:0], f[22:0]};
  endfunction

  function automatic string tag_of(input logic sh, input logic [31:0] w);
    if (sh && w[15:12] == 4'b1000) return "R5";
    if (sh) return "R6/R7";
    if (w[31:24] == 8'h80) return "R2";
    if (w[23] && w[31:24] == 8'h7F && w[22:0] == 23'h0) return "R4";
    if (w[23]) return "R3";
    return "R1";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] got, input logic [35:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic send(input logic sh, input logic [31:0] w);
    logic [33:0] e;
    in_valid = 1'b1;
    in_short = sh;
    in_word  = w;
    e = model(sh, w);
    @(negedge clk);
    check(out_valid && ({out_zero, out_ovf, out_ieee} == e) && !(out_zero && out_ovf),
          tag_of(sh, w), {1'b0, out_valid, out_zero, out_ovf, out_ieee}, {2'b01, e});
  endtask

  function automatic logic [22:0] pick_frac(input int k);
    case (k)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h7FFFFF;
      3: return 23'h400000;
      4: return 23'h3FFFFF;
      5: return 23'h000800;
      6: return 23'h555555;
      default: return 23'h2AAAAA;
    endcase
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held;
    logic        hz;
    logic        ho;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!out_valid && out_ieee == 32'h0 && !out_zero && !out_ovf, "R8 reset",
          {1'b0, out_valid, out_zero, out_ovf, out_ieee}, 36'h0);
    rst = 1'b0;

    // Directed corners
    send(1'b0, 32'h00000000);   // R1: 1.0 -> 3F800000
    send(1'b0, 32'h80ABCDEF);   // R2: reserved zero, junk bits
    send(1'b0, 32'h7F800000);   // R4: -2^128 -> -inf
    send(1'b0, 32'h81800000);   // R3: carry at smallest exponent
    send(1'b0, 32'h7F7FFFFF);   // R1: largest positive
    send(1'b0, 32'h81000000);   // R1: exponent -127
    send(1'b1, 32'hFFFF8FFF);   // R5: short zero with junk upper half

    // R5 R6 R7: every short float, upper half never matching the low half
    for (int i = 0; i < 65536; i++)
      send(1'b1, {i[15:0] ^ 16'hA5C3, i[15:0]});

    // R1 R2 R3 R4: all exponents, both signs, boundary fractions
    for (int e = 0; e < 256; e++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 8; k++)
          send(1'b0, {e[7:0], s[0], pick_frac(k)});

    // Random full words
    for (int i = 0; i < 3000; i++)
      send(1'b0, $urandom);

    // R9 R8: idle cycles with changing data keep results, drop valid
    send(1'b0, 32'h05123456);
    held = out_ieee; hz = out_zero; ho = out_ovf;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b0;
      in_short = i[0];
      in_word  = $urandom;
      @(negedge clk);
      check(!out_valid && out_ieee == held && out_zero == hz && out_ovf == ho, "R9 hold",
            {1'b0, out_valid, out_zero, out_ovf, out_ieee}, {2'b00, hz, ho, held});
    end

    // R7: upper half alone varies in short mode
    send(1'b1, 32'h00003ABC);
    held = out_ieee;
    send(1'b1, 32'hFFFF3ABC);
    check(out_ieee == held, "R7 upper ignored", {4'h0, out_ieee}, {4'h0, held});

    // R8: reset during a stream clears outputs
    in_valid = 1'b1;
    in_short = 1'b0;
    in_word  = 32'h02400000;
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && out_ieee == 32'h0 && !out_zero && !out_ovf, "R8 mid reset",
          {1'b0, out_valid, out_zero, out_ovf, out_ieee}, 36'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule